// File: doc/BRIEF.md
# Byte SPI Transceiver with Flagged Status Register

This block moves bytes across a four-wire serial link, acting either as the clock-driving side (master) or as the clock-following side (slave). Software talks to it through a small register port with three locations. Location 0 is a combined control and status byte. Location 1 is a transmit holding register. Location 2 is a receive holding register. Both data paths are double buffered: the next outgoing byte can be queued while the current one shifts, and a received byte stays readable while the next one arrives.

The serial engine is a three-state machine. `ST_IDLE` waits for work. In master mode, work is a queued transmit byte; in slave mode, it is an active select line. Leaving `ST_IDLE` loads the shifter (the "start" transition). `ST_LEAD` waits for the leading clock edge, and that edge moves the machine to `ST_TRAIL`. `ST_TRAIL` waits for the trailing edge. On that edge the machine returns to `ST_LEAD` for the next bit. On the eighth trailing edge it either reloads and goes to `ST_LEAD` (the "chain" transition) or falls back to `ST_IDLE` (the "finish" transition). Two more transitions go to `ST_IDLE` from any state: clearing the enable bit ("abort"), and, in slave mode, releasing the select line ("deselect").

In master mode each pulse on `bit_tick` produces one half period of the serial clock. In slave mode the serial clock, select and data inputs pass through a two-stage synchroniser, and their edges are detected in the system clock domain. A single interrupt line reflects one flag, chosen by the mode or by `irq_on_done`.

Top module: `spi_xcvr`

## Requirements
- R1: After reset, location 0 reads 0x00. Its layout is bit7 lsb_first, bit6 overrun, bit5 complete, bit4 tx_empty, bit3 rx_full, bit2 cpha, bit1 cpol and bit0 enable. Only bits 7, 2, 1 and 0 take written values. tx_empty reads as 0 whenever enable is 0.
- R2: With lsb_first=0 the byte goes out and comes in most significant bit first. With lsb_first=1 it goes least significant bit first.
- R3: With cpol=0 the serial clock idles low, and with cpol=1 it idles high. With cpha=0, data is sampled on the leading edge and changes on the trailing edge. With cpha=1, data changes on the leading edge and is sampled on the trailing edge.
- R4: In master mode a transfer takes 16 `bit_tick` pulses, one per clock half period. `ss_n_o` is low from load until the last trailing edge and high otherwise.
- R5: Writing location 1 clears tx_empty. When the engine is idle (master) or starts a byte with the holding register full, it copies the byte into the shifter and tx_empty sets again, so a second byte can be queued during the first.
- R6: After 8 bits the received byte is copied into location 2, and rx_full and complete set. A read of location 2 clears rx_full.
- R7: If rx_full is still set when a new byte is copied in, overrun sets.
- R8: A read of location 0 clears overrun and complete, unless a byte finishes in the same cycle.
- R9: The interrupt is complete when `irq_on_done`=1. Otherwise it is tx_empty in master mode and rx_full in slave mode.
- R10: Clearing enable returns the serial clock to its idle level, raises `ss_n_o`, aborts any transfer and leaves locations 1 and 2 unchanged.
- R11: In slave mode bits shift only while `ss_n_i` is low. Raising it partway through a byte discards the partial bit count, and the next selected byte is received whole.
- R12: In slave mode `miso_o` presents the transmit byte and `mosi_i` is captured, both with the edge rules of R2 and R3, on `sclk_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register location: 0 control/status, 1 transmit, 2 receive |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read side effects take place on the clock edge |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data of the addressed location |
| is_master | input | 1 | 1 selects master mode, 0 selects slave mode |
| irq_on_done | input | 1 | 1 makes complete the interrupt source |
| bit_tick | input | 1 | Half-period pulse for the master serial clock |
| sclk_o | output | 1 | Master serial clock |
| ss_n_o | output | 1 | Master select, active low |
| mosi_o | output | 1 | Master data out |
| miso_i | input | 1 | Master data in |
| sclk_i | input | 1 | Slave serial clock |
| ss_n_i | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| irq | output | 1 | Interrupt request |

## Verification
Overrun and chained transfers are the hard cases, because both need a second byte to finish before software reacts to the first. The stimulus creates them in two ways. In master mode it queues a second byte as soon as tx_empty returns and leaves location 2 unread. In slave mode it clocks two selected bytes back to back with no read between them. The partial-byte deselect needs the bench to stop clocking after three bits and release select. The next transfer must then arrive whole, which shows that the bit counter restarted. Random bytes and random settings of order, phase and polarity cover the remaining cases.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } xfer_st_e;

    typedef struct packed {
        logic lsb_first;
        logic cpha;
        logic cpol;
        logic en;
    } spi_cfg_t;

    localparam logic [1:0] LOC_CSR = 2'd0;
    localparam logic [1:0] LOC_TXD = 2'd1;
    localparam logic [1:0] LOC_RXD = 2'd2;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_regs.sv
module spi_regs
    import spi_xcvr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          is_master,
    input  logic          irq_on_done,
    input  logic          pop,
    input  logic          byte_done,
    input  logic [DW-1:0] rx_word,
    output spi_cfg_t      cfg,
    output logic [DW-1:0] hold_data,
    output logic          hold_full,
    output logic          irq
);
    logic [DW-1:0] rx_q;
    logic          rxf_q, ovr_q, done_q;
    logic          wr_csr, wr_tx, rd_csr, rd_rx, txe;
    logic [7:0]    status;

    assign wr_csr = bus_wr && (bus_addr == LOC_CSR);
    assign wr_tx  = bus_wr && (bus_addr == LOC_TXD);
    assign rd_csr = bus_rd && (bus_addr == LOC_CSR);
    assign rd_rx  = bus_rd && (bus_addr == LOC_RXD);
    assign txe    = cfg.en && !hold_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg       <= '0;
            hold_data <= '0;
            hold_full <= 1'b0;
            rx_q      <= '0;
            rxf_q     <= 1'b0;
            ovr_q     <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            if (wr_csr)
                cfg <= '{lsb_first: bus_wdata[7], cpha: bus_wdata[2],
                         cpol: bus_wdata[1], en: bus_wdata[0]};
            if (wr_tx) begin
                hold_data <= bus_wdata;
                hold_full <= 1'b1;
            end else if (pop) begin
                hold_full <= 1'b0;
            end
            if (byte_done) begin
                rx_q   <= rx_word;
                rxf_q  <= 1'b1;
                done_q <= 1'b1;
                if (rxf_q && !rd_rx) ovr_q <= 1'b1;
                else if (rd_csr)     ovr_q <= 1'b0;
            end else begin
                if (rd_rx)  rxf_q  <= 1'b0;
                if (rd_csr) begin
                    done_q <= 1'b0;
                    ovr_q  <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        status = {cfg.lsb_first, ovr_q, done_q, txe, rxf_q,
                  cfg.cpha, cfg.cpol, cfg.en};
        unique case (bus_addr)
            LOC_CSR: bus_rdata = DW'(status);
            LOC_TXD: bus_rdata = hold_data;
            LOC_RXD: bus_rdata = rx_q;
            default: bus_rdata = '0;
        endcase
        if (irq_on_done)    irq = cfg.en && done_q;
        else if (is_master) irq = txe;
        else                irq = cfg.en && rxf_q;
    end

    // R5
    tx_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx |=> hold_full);
    // R6
    rx_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rx && !byte_done |=> !rxf_q);
    // R7
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done && rxf_q && !rd_rx |=> ovr_q);
    // R8
    status_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_csr && !byte_done |=> !done_q && !ovr_q);
endmodule

// File: rtl/spi_engine.sv
module spi_engine
    import spi_xcvr_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  spi_cfg_t      cfg,
    input  logic          is_master,
    input  logic          bit_tick,
    input  logic [DW-1:0] hold_data,
    input  logic          hold_full,
    input  logic          sclk_i,
    input  logic          ss_n_i,
    input  logic          mosi_i,
    input  logic          miso_i,
    output logic          pop,
    output logic          byte_done,
    output logic [DW-1:0] rx_word,
    output logic          sclk_o,
    output logic          ss_n_o,
    output logic          mosi_o,
    output logic          miso_o
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

    xfer_st_e      st_q, st_n;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] sh_q, rx_sh_q, rx_shift;
    logic          s_sclk, s_ss_n, s_mosi, sclk_d;
    logic          ss_act, lead_ev, trail_ev, sample_ev, shift_ev;
    logic          load, in_bit, out_bit;

    spi_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_i, ss_n_i, mosi_i}),
        .q     ({s_sclk, s_ss_n, s_mosi})
    );

    assign ss_act = !s_ss_n;

    always_comb begin
        if (is_master) begin
            lead_ev  = bit_tick && (st_q == ST_LEAD);
            trail_ev = bit_tick && (st_q == ST_TRAIL);
        end else begin
            lead_ev  = (st_q == ST_LEAD) && (sclk_d == cfg.cpol) && (s_sclk != cfg.cpol);
            trail_ev = (st_q == ST_TRAIL) && (sclk_d != cfg.cpol) && (s_sclk == cfg.cpol);
        end
        sample_ev = cfg.cpha ? trail_ev : lead_ev;
        shift_ev  = cfg.cpha ? (lead_ev && (cnt_q != '0)) : trail_ev;
        in_bit    = is_master ? miso_i : s_mosi;
        rx_shift  = cfg.lsb_first ? {in_bit, rx_sh_q[DW-1:1]} : {rx_sh_q[DW-2:0], in_bit};
        rx_word   = sample_ev ? rx_shift : rx_sh_q;
        byte_done = trail_ev && (cnt_q == LAST_BIT);
    end

    // next-state logic
    always_comb begin
        st_n = st_q;
        load = 1'b0;
        if (!cfg.en || (!is_master && !ss_act)) begin
            st_n = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (is_master ? hold_full : 1'b1) begin
                        st_n = ST_LEAD;
                        load = 1'b1;
                    end
                end
                ST_LEAD: begin
                    if (lead_ev) st_n = ST_TRAIL;
                end
                ST_TRAIL: begin
                    if (trail_ev) begin
                        if (cnt_q != LAST_BIT) begin
                            st_n = ST_LEAD;
                        end else if (is_master ? hold_full : 1'b1) begin
                            st_n = ST_LEAD;
                            load = 1'b1;
                        end else begin
                            st_n = ST_IDLE;
                        end
                    end
                end
                default: st_n = ST_IDLE;
            endcase
        end
        pop = load && hold_full;
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            rx_sh_q <= '0;
            sclk_d  <= 1'b0;
        end else begin
            st_q   <= st_n;
            sclk_d <= s_sclk;
            if (load) begin
                cnt_q <= '0;
                if (hold_full) sh_q <= hold_data;
            end else begin
                if (shift_ev) sh_q <= cfg.lsb_first ? (sh_q >> 1) : (sh_q << 1);
                if (trail_ev) cnt_q <= cnt_q + 1'b1;
            end
            if (st_n == ST_IDLE) cnt_q <= '0;
            if (sample_ev) rx_sh_q <= rx_shift;
        end
    end

    // outputs
    always_comb begin
        out_bit = cfg.lsb_first ? sh_q[0] : sh_q[DW-1];
        sclk_o  = (is_master && st_q == ST_TRAIL) ? !cfg.cpol : cfg.cpol;
        ss_n_o  = !(is_master && st_q != ST_IDLE);
        mosi_o  = is_master ? out_bit : 1'b0;
        miso_o  = is_master ? 1'b0 : out_bit;
    end

    // R10
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> st_q == ST_IDLE);
    // R11
    slave_deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master && s_ss_n |=> st_q == ST_IDLE && cnt_q == '0);
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
    import spi_xcvr_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          is_master,
    input  logic          irq_on_done,
    input  logic          bit_tick,
    output logic          sclk_o,
    output logic          ss_n_o,
    output logic          mosi_o,
    input  logic          miso_i,
    input  logic          sclk_i,
    input  logic          ss_n_i,
    input  logic          mosi_i,
    output logic          miso_o,
    output logic          irq
);
    spi_cfg_t      cfg;
    logic [DW-1:0] hold_data, rx_word;
    logic          hold_full, pop, byte_done;

    spi_regs #(.DW(DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .is_master   (is_master),
        .irq_on_done (irq_on_done),
        .pop         (pop),
        .byte_done   (byte_done),
        .rx_word     (rx_word),
        .cfg         (cfg),
        .hold_data   (hold_data),
        .hold_full   (hold_full),
        .irq         (irq)
    );

    spi_engine #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .is_master (is_master),
        .bit_tick  (bit_tick),
        .hold_data (hold_data),
        .hold_full (hold_full),
        .sclk_i    (sclk_i),
        .ss_n_i    (ss_n_i),
        .mosi_i    (mosi_i),
        .miso_i    (miso_i),
        .pop       (pop),
        .byte_done (byte_done),
        .rx_word   (rx_word),
        .sclk_o    (sclk_o),
        .ss_n_o    (ss_n_o),
        .mosi_o    (mosi_o),
        .miso_o    (miso_o)
    );

    // R4
    master_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> ss_n_o);
endmodule

// File: tb/spi_xcvr_bench.sv
`timescale 1ns/1ps
module spi_xcvr_bench;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       is_master = 1'b1, irq_on_done = 1'b0, bit_tick = 1'b0;
    logic       sclk_o, ss_n_o, mosi_o, miso_o, irq;
    logic       sclk_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0;

    int n_chk = 0, n_err = 0;
    logic cur_cpha = 1'b0, cur_cpol = 1'b0;

    always #2 clk = ~clk;

    spi_xcvr u_spi_xcvr (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .is_master(is_master), .irq_on_done(irq_on_done), .bit_tick(bit_tick),
        .sclk_o(sclk_o), .ss_n_o(ss_n_o), .mosi_o(mosi_o), .miso_i(mosi_o),
        .sclk_i(sclk_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i), .miso_o(miso_o),
        .irq(irq)
    );

    // master-side line monitor: records mosi_o at each sampling edge of sclk_o
    logic       mon_bits [64];
    int         mon_total = 0;
    logic       sck_p = 1'b0, mosi_p = 1'b0, ssn_p = 1'b1;
    always @(negedge clk) begin
        if (is_master && (sclk_o != sck_p) && (!ss_n_o || !ssn_p) &&
            ((sclk_o != cur_cpol) == !cur_cpha)) begin
            mon_bits[mon_total % 64] <= mosi_p;
            mon_total <= mon_total + 1;
        end
        sck_p  <= sclk_o;
        mosi_p <= mosi_o;
        ssn_p  <= ss_n_o;
    end

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
        end
    end

    // bit i of the result is the i-th bit on the wire
    function automatic logic [7:0] wire_seq(input logic [7:0] b, input logic lsb);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = lsb ? b[i] : b[7-i];
        return r;
    endfunction

    function automatic logic [7:0] exp_status(input logic lsb, ovr, done, txe, rxf,
                                              cpha, cpol, en);
        return {lsb, ovr, done, txe & en, rxf, cpha, cpol, en};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_cfg(input logic lsb, cpha, cpol, en);
        cur_cpha = cpha; cur_cpol = cpol;
        sclk_i = cpol;
        bwrite(2'd0, {lsb, 4'b0, cpha, cpol, 1'b0});
        if (en) bwrite(2'd0, {lsb, 4'b0, cpha, cpol, 1'b1});
    endtask

    function automatic logic [7:0] mon_seq(input int start);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = mon_bits[(start + i) % 64];
        return r;
    endfunction

    // bench acting as master towards the slave pins
    task automatic slave_xfer(input logic [7:0] mb, input int nbits, input logic cpha,
                              cpol, lsb, output logic [7:0] cap);
        logic [7:0] seq;
        seq = wire_seq(mb, lsb);
        cap = '0;
        @(negedge clk);
        sclk_i = cpol; ss_n_i = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            if (!cpha) begin
                mosi_i = seq[i];
                repeat (H) @(negedge clk);
                sclk_i = !cpol; cap[i] = miso_o;
                repeat (H) @(negedge clk);
                sclk_i = cpol;
            end else begin
                sclk_i = !cpol; mosi_i = seq[i];
                repeat (H) @(negedge clk);
                sclk_i = cpol; cap[i] = miso_o;
                repeat (H) @(negedge clk);
            end
        end
        repeat (H) @(negedge clk);
        ss_n_i = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d, tb, mb, cap, b2;
        logic lsb, cpha, cpol;
        int start;
        void'($urandom(32'd1357));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        bread(2'd0, d);
        check("R1 reset status", d, 8'h00);
        check("R9 reset irq", irq, 1'b0);
        check("R3 reset sclk idle", sclk_o, 1'b0);
        check("R4 reset select", ss_n_o, 1'b1);
        bwrite(2'd0, 8'hFF);
        bread(2'd0, d);
        check("R1 read-only bits", d, 8'h97);
        bwrite(2'd0, 8'h00);

        // R2 R3 R4 R5 R6 master random transfers (loopback)
        is_master = 1'b1;
        for (int it = 0; it < 12; it++) begin
            tb = 8'($urandom); lsb = 1'($urandom); cpha = 1'($urandom); cpol = 1'($urandom);
            set_cfg(lsb, cpha, cpol, 1'b1);
            start = mon_total;
            bwrite(2'd1, tb);
            repeat (30) @(negedge clk);
            check("R4 select low mid-transfer", ss_n_o, 1'b0);
            repeat (80) @(negedge clk);
            check("R4 select high after", ss_n_o, 1'b1);
            check("R3 sclk idle level", sclk_o, cpol);
            check("R4 edge count", mon_total - start, 8);
            check("R2 R3 wire order", mon_seq(start), wire_seq(tb, lsb));
            bread(2'd0, d);
            check("R6 status after byte", d, exp_status(lsb, 0, 1, 1, 1, cpha, cpol, 1));
            bread(2'd2, d);
            check("R6 rx data", d, tb);
            bread(2'd0, d);
            check("R8 status cleared", d, exp_status(lsb, 0, 0, 1, 0, cpha, cpol, 1));
        end

        // R5 R7 back-to-back master bytes without reading rx
        set_cfg(1'b0, 1'b0, 1'b0, 1'b1);
        start = mon_total;
        bwrite(2'd1, 8'hA5);
        repeat (3) @(negedge clk);
        bread(2'd0, d);
        check("R5 tx_empty after move", d[4], 1'b1);
        bwrite(2'd1, 8'h3C);
        bread(2'd0, d);
        check("R5 tx_empty cleared by write", d[4], 1'b0);
        repeat (200) @(negedge clk);
        check("R5 two bytes on wire", {mon_seq(start + 8), mon_seq(start)},
              {wire_seq(8'h3C, 0), wire_seq(8'hA5, 0)});
        check("R9 master irq tx_empty", irq, 1'b1);
        bread(2'd0, d);
        check("R7 overrun", d, exp_status(0, 1, 1, 1, 1, 0, 0, 1));
        bread(2'd0, d);
        check("R8 overrun cleared", d, exp_status(0, 0, 0, 1, 1, 0, 0, 1));
        bread(2'd2, d);
        check("R7 rx holds newer byte", d, 8'h3C);

        // R10 abort mid-transfer
        bwrite(2'd1, 8'h77);
        repeat (2) @(negedge clk);
        bwrite(2'd2, 8'h00);
        set_cfg(1'b0, 1'b0, 1'b1, 1'b1);
        bread(2'd2, d);
        bwrite(2'd1, 8'h5A);
        repeat (200) @(negedge clk);
        bread(2'd0, d);
        bread(2'd2, b2);
        bwrite(2'd1, 8'hC3);
        repeat (20) @(negedge clk);
        bwrite(2'd0, 8'h02);
        repeat (2) @(negedge clk);
        check("R10 sclk idle after abort", sclk_o, 1'b1);
        check("R10 select high after abort", ss_n_o, 1'b1);
        repeat (100) @(negedge clk);
        bread(2'd0, d);
        check("R10 no completion after abort", d, 8'h02);
        bread(2'd2, d);
        check("R10 rx unchanged", d, b2);
        bwrite(2'd0, 8'h03);
        repeat (40) @(negedge clk);
        check("R10 no transfer after re-enable", ss_n_o, 1'b1);

        // R9 interrupt source choice, master
        check("R9 master irq follows tx_empty", irq, 1'b1);
        irq_on_done = 1'b1;
        #1 check("R9 irq follows complete", irq, 1'b0);
        irq_on_done = 1'b0;
        bwrite(2'd0, 8'h00);

        // R11 R12 slave random transfers
        is_master = 1'b0;
        for (int it = 0; it < 8; it++) begin
            tb = 8'($urandom); mb = 8'($urandom);
            lsb = 1'($urandom); cpha = 1'($urandom); cpol = 1'($urandom);
            set_cfg(lsb, cpha, cpol, 1'b1);
            bwrite(2'd1, tb);
            slave_xfer(mb, 8, cpha, cpol, lsb, cap);
            check("R12 miso wire order", cap, wire_seq(tb, lsb));
            bread(2'd0, d);
            check("R6 slave status", d, exp_status(lsb, 0, 1, 1, 1, cpha, cpol, 1));
            bread(2'd2, d);
            check("R11 slave rx data", d, mb);
        end

        // R11 deselect partway through a byte
        set_cfg(1'b0, 1'b1, 1'b0, 1'b1);
        bwrite(2'd1, 8'hF0);
        slave_xfer(8'hFF, 3, 1'b1, 1'b0, 1'b0, cap);
        bread(2'd0, d);
        check("R11 partial byte not counted", d, exp_status(0, 0, 0, 1, 0, 1, 0, 1));
        bwrite(2'd1, 8'h96);
        slave_xfer(8'h2B, 8, 1'b1, 1'b0, 1'b0, cap);
        check("R11 miso after restart", cap, wire_seq(8'h96, 0));
        bread(2'd2, d);
        check("R11 rx whole after restart", d, 8'h2B);
        bread(2'd0, d);

        // R7 R9 slave overrun and interrupt selection
        set_cfg(1'b1, 1'b0, 1'b0, 1'b1);
        bwrite(2'd1, 8'h11);
        slave_xfer(8'h81, 8, 1'b0, 1'b0, 1'b1, cap);
        check("R9 slave irq follows rx_full", irq, 1'b1);
        bwrite(2'd1, 8'h22);
        slave_xfer(8'h42, 8, 1'b0, 1'b0, 1'b1, cap);
        irq_on_done = 1'b1;
        #1 check("R9 irq complete set", irq, 1'b1);
        bread(2'd0, d);
        check("R7 slave overrun", d, exp_status(1, 1, 1, 1, 1, 0, 0, 1));
        check("R9 irq complete cleared", irq, 1'b0);
        irq_on_done = 1'b0;
        #1 check("R9 slave irq still rx_full", irq, 1'b1);
        bread(2'd2, d);
        check("R7 slave rx newest", d, 8'h42);
        check("R9 slave irq after rx read", irq, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule